// File: doc/BRIEF.md
# One-Wire Temperature Sensor Slave Model

This block is a synthesizable slave for a single-wire, open-drain bus. It acts as a digital temperature sensor and gives a bus master under test a partner to talk to. It runs from a 1 MHz clock, so each cycle is one microsecond.

It sees the bus only through one input, which it passes through a two-stage synchroniser. It can only pull the bus low, through an enable output. The block works out what the master wants by measuring how long each low lasts:

- A long low is a bus reset. The block answers it with a presence pulse.
- Short lows are write slots or read slots.

After a reset the block expects a skip-addressing byte (CCh). That byte may be followed by one of two commands:

- **44h** starts a conversion. When the conversion ends, the value on the temperature input is latched into a 16-bit scratchpad.
- **BEh** switches the block to read slots. In read slots it returns the scratchpad least significant bit first. The block sends a 0 by holding the bus low through the master's sample point, and sends a 1 by leaving the bus alone.

Top module: `onewire_sensor_slave`

## Requirements
- R1: A bus low of RESET_MIN_US (480) cycles or more, measured after synchronisation, is a bus reset and is acted on when the bus rises. Any shorter low is never taken as a reset.
- R2: After a reset the block waits PRES_WAIT_US (20) cycles and then pulls the bus for PRES_LEN_US (120) cycles. As a result the bus reads low 100 µs after the master releases it, and it is released again by 300 µs after that release.
- R3: A write slot is sampled SAMPLE_US (22) cycles after its detected falling edge. A low bus at that point is a 0 and a high bus is a 1. Command bytes are assembled least significant bit first.
- R4: The first byte after a reset must be CCh. Any other byte makes the block ignore the bus until the next reset, and it then never pulls the bus in read slots.
- R5: The byte 44h after CCh starts a conversion of CONV_US cycles. When the conversion ends, temp_in is copied into the scratchpad. The scratchpad changes at no other time.
- R6: A bus reset that arrives while a conversion is running does not cancel the conversion.
- R7: The byte BEh after CCh enters read mode, in which each read slot returns the next scratchpad bit, starting at bit 0.
  - For a 0 bit the block pulls the bus from edge detection for READ0_HOLD_US (45) cycles.
  - For a 1 bit it does not pull the bus.
- R8: Read slots after the 16 scratchpad bits return 1.
- R9: A second byte after CCh other than 44h or BEh makes the block ignore the bus until the next reset.
- R10: A falling edge seen while a timed response is running (presence wait or pull, write-slot sample wait, read-0 hold) is ignored. A bus reset is honoured in every state.
- R11: After rst_n the scratchpad holds SCRATCH_INIT (0550h) and bus_pull is 0. Slots seen before the first bus reset get no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1 MHz clock, one cycle per microsecond |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_in | input | 1 | Level of the open-drain bus (asynchronous) |
| temp_in | input | 16 | Temperature value latched when a conversion ends |
| bus_pull | output | 1 | 1 drives the bus low; 0 releases it |

## Verification
Most wrong internal states show up as a wrong level on bus_pull within one slot, which is less than 100 µs.

- **Lost or extra bit count.** The command is misdecoded, and every following read slot comes back as 1s. The bench sees this on the first read slot after the command.
- **Wrong read index.** The returned value is rotated or truncated. This appears across the 16 read slots.
- **Bad conversion timer or latch.** This only shows up on a later reset-and-read, so the bench reads the scratchpad both before and after a conversion is due, and again after temp_in changes.

// File: rtl/ow_pkg.sv
// Shared types and command codes for the single-wire sensor slave.
package ow_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,       // ignore slots until a bus reset
        ST_PRES_WAIT,  // delay before presence pulse
        ST_PRES_PULL,  // presence pulse being driven
        ST_RX,         // waiting for a write-slot falling edge
        ST_RX_WAIT,    // timing to the write-slot sample point
        ST_TX,         // waiting for a read-slot falling edge
        ST_TX_HOLD     // holding the bus low for a 0 bit
    } ow_state_e;

    localparam logic [7:0] CMD_SKIP    = 8'hCC;
    localparam logic [7:0] CMD_CONVERT = 8'h44;
    localparam logic [7:0] CMD_READ    = 8'hBE;
endpackage

// File: rtl/ow_bus_monitor.sv
// Bus monitor: synchronises the raw bus level through two flops, flags
// falling edges, and measures each low period. When the bus rises after a
// long enough low, it raises reset_det for one cycle.
// Assumes the bus idles high and that clk runs at 1 MHz.
module ow_bus_monitor #(
    parameter int RESET_MIN_US = 480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_in,
    output logic bus_s,
    output logic fall,
    output logic reset_det
);
    localparam int LW = $clog2(RESET_MIN_US + 1);
    localparam logic [LW-1:0] LSAT = LW'(RESET_MIN_US);

    logic sync1, sync2, bus_d;
    logic [LW-1:0] low_cnt;

    // Two-flop synchroniser plus a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
            bus_d <= 1'b1;
        end else begin
            sync1 <= bus_in;
            sync2 <= sync1;
            bus_d <= sync2;
        end
    end

    assign bus_s = sync2;
    assign fall  = bus_d & ~sync2;

    // Saturating count of synchronised low cycles since the last fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (fall) begin
            low_cnt <= LW'(1);
        end else if (!sync2 && low_cnt != LSAT) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign reset_det = ~bus_d & sync2 & (low_cnt == LSAT);
endmodule

// File: rtl/ow_convert.sv
// Conversion unit: once started, counts CONV_US cycles, then copies the
// temperature input into the scratchpad and pulses done for one cycle.
// A new start while busy restarts the count. Assumes temp_in is stable
// at the completing edge.
module ow_convert #(
    parameter int                 CONV_US = 750000,
    parameter int                 DATA_W  = 16,
    parameter logic [DATA_W-1:0]  INIT    = 16'h0550
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] temp_in,
    output logic [DATA_W-1:0] scratch,
    output logic              done
);
    localparam int CW = $clog2(CONV_US + 1);
    localparam logic [CW-1:0] LAST = CW'(CONV_US - 1);

    logic          busy;
    logic [CW-1:0] cnt;

    // Conversion countdown and scratchpad latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cnt     <= '0;
            scratch <= INIT;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (busy) begin
                if (cnt == LAST) begin
                    busy    <= 1'b0;
                    scratch <= temp_in;
                    done    <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/onewire_sensor_slave.sv
// Single-wire temperature sensor slave.
// - Detects bus resets and answers each one with a presence pulse.
// - Decodes a skip-addressing byte followed by either a convert command
//   or a read command.
// - Serves the scratchpad in read slots.
// Assumes a 1 MHz clock, an external pull-up on the bus, and an
// open-drain driver built from bus_pull.
module onewire_sensor_slave #(
    parameter int                RESET_MIN_US  = 480,
    parameter int                PRES_WAIT_US  = 20,
    parameter int                PRES_LEN_US   = 120,
    parameter int                SAMPLE_US     = 22,
    parameter int                READ0_HOLD_US = 45,
    parameter int                CONV_US       = 750000,
    parameter int                DATA_W        = 16,
    parameter logic [DATA_W-1:0] SCRATCH_INIT  = 16'h0550
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_in,
    input  logic [DATA_W-1:0] temp_in,
    output logic              bus_pull
);
    import ow_pkg::*;

    localparam int TMAX1 = (PRES_WAIT_US > PRES_LEN_US) ? PRES_WAIT_US : PRES_LEN_US;
    localparam int TMAX2 = (SAMPLE_US > READ0_HOLD_US) ? SAMPLE_US : READ0_HOLD_US;
    localparam int TMAX  = (TMAX1 > TMAX2) ? TMAX1 : TMAX2;
    localparam int TW    = $clog2(TMAX + 1);
    localparam int IW    = $clog2(DATA_W + 1);
    localparam int SW    = $clog2(DATA_W);

    localparam logic [TW-1:0] T_PWAIT = TW'(PRES_WAIT_US - 1);
    localparam logic [TW-1:0] T_PLEN  = TW'(PRES_LEN_US - 1);
    localparam logic [TW-1:0] T_SAMP  = TW'(SAMPLE_US - 1);
    localparam logic [TW-1:0] T_HOLD  = TW'(READ0_HOLD_US - 1);
    localparam logic [IW-1:0] I_END   = IW'(DATA_W);

    logic              bus_s, bus_fall, reset_det;
    logic [DATA_W-1:0] scratch;
    logic              conv_done, conv_go;
    ow_state_e         state;
    logic [TW-1:0]     tmr;
    logic [7:0]        shreg;
    logic [2:0]        bcnt;
    logic              rom_phase;
    logic [IW-1:0]     rd_idx;
    logic [7:0]        byte_n;
    logic              tx_bit;

    ow_bus_monitor #(.RESET_MIN_US(RESET_MIN_US)) u_mon (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in),
        .bus_s(bus_s), .fall(bus_fall), .reset_det(reset_det)
    );

    ow_convert #(.CONV_US(CONV_US), .DATA_W(DATA_W), .INIT(SCRATCH_INIT)) u_conv (
        .clk(clk), .rst_n(rst_n), .start(conv_go), .temp_in(temp_in),
        .scratch(scratch), .done(conv_done)
    );

    // Next byte value and outgoing read bit.
    always_comb begin
        byte_n = {bus_s, shreg[7:1]};
        tx_bit = (rd_idx < I_END) ? scratch[rd_idx[SW-1:0]] : 1'b1;
    end

    // Main slot sequencer: presence, command reception, read responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            tmr       <= '0;
            shreg     <= '0;
            bcnt      <= '0;
            rom_phase <= 1'b1;
            rd_idx    <= '0;
            bus_pull  <= 1'b0;
            conv_go   <= 1'b0;
        end else begin
            conv_go <= 1'b0;
            if (reset_det) begin
                state     <= ST_PRES_WAIT;
                tmr       <= '0;
                bcnt      <= '0;
                rom_phase <= 1'b1;
                rd_idx    <= '0;
                bus_pull  <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_PRES_WAIT: begin
                        tmr <= tmr + 1'b1;
                        if (tmr == T_PWAIT) begin
                            state    <= ST_PRES_PULL;
                            bus_pull <= 1'b1;
                            tmr      <= '0;
                        end
                    end
                    ST_PRES_PULL: begin
                        tmr <= tmr + 1'b1;
                        if (tmr == T_PLEN) begin
                            state    <= ST_RX;
                            bus_pull <= 1'b0;
                            tmr      <= '0;
                        end
                    end
                    ST_RX: begin
                        if (bus_fall) begin
                            state <= ST_RX_WAIT;
                            tmr   <= '0;
                        end
                    end
                    ST_RX_WAIT: begin
                        tmr <= tmr + 1'b1;
                        if (tmr == T_SAMP) begin
                            shreg <= byte_n;
                            bcnt  <= bcnt + 1'b1;
                            state <= ST_RX;
                            if (bcnt == 3'd7) begin
                                if (rom_phase) begin
                                    if (byte_n == CMD_SKIP) rom_phase <= 1'b0;
                                    else                    state     <= ST_IDLE;
                                end else if (byte_n == CMD_CONVERT) begin
                                    conv_go <= 1'b1;
                                    state   <= ST_IDLE;
                                end else if (byte_n == CMD_READ) begin
                                    state  <= ST_TX;
                                    rd_idx <= '0;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                        end
                    end
                    ST_TX: begin
                        if (bus_fall) begin
                            if (rd_idx != I_END) rd_idx <= rd_idx + 1'b1;
                            if (!tx_bit) begin
                                bus_pull <= 1'b1;
                                state    <= ST_TX_HOLD;
                                tmr      <= '0;
                            end
                        end
                    end
                    ST_TX_HOLD: begin
                        tmr <= tmr + 1'b1;
                        if (tmr == T_HOLD) begin
                            bus_pull <= 1'b0;
                            state    <= ST_TX;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/ow_slave_chk.sv
// Assertion checker for the single-wire sensor slave, bound into the top.
module ow_slave_chk #(
    parameter int MAX_PULL = 120,
    parameter int IW       = 5,
    parameter int DATA_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_pull,
    input logic              reset_det,
    input logic              fall,
    input ow_pkg::ow_state_e state,
    input logic [IW-1:0]     ridx,
    input logic [DATA_W-1:0] scratch,
    input logic              conv_done
);
    import ow_pkg::*;
    localparam int PW = $clog2(MAX_PULL + 2);
    logic [PW-1:0] pull_run;

    // Length of the current continuous pull, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !bus_pull)                pull_run <= '0;
        else if (pull_run != PW'(MAX_PULL + 1)) pull_run <= pull_run + 1'b1;
    end

    // R1
    reset_to_presence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_det |=> (state == ST_PRES_WAIT));
    // R2
    presence_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_det |=> !bus_pull);
    // R2
    pull_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pull_run <= PW'(MAX_PULL));
    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !bus_pull);
    // R5
    scratch_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scratch) |-> conv_done);
    // R8
    tail_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX && fall && !reset_det && ridx == IW'(DATA_W)) |=> !bus_pull);
endmodule

bind onewire_sensor_slave ow_slave_chk #(.MAX_PULL(PRES_LEN_US), .IW(IW), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_pull(bus_pull), .reset_det(reset_det),
    .fall(bus_fall), .state(state), .ridx(rd_idx), .scratch(scratch),
    .conv_done(conv_done)
);

// File: tb/sim_onewire_sensor_slave.sv
module sim_onewire_sensor_slave;
    localparam int CLK_PERIOD = 10;
    localparam int CONV = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_low = 1'b0;
    logic [15:0] temp_in = 16'h0000;
    logic        bus_pull;
    logic        bus_in;
    int          n_chk = 0;
    int          n_fail = 0;

    assign bus_in = ~(m_low | bus_pull);

    always #(CLK_PERIOD / 2) clk = ~clk;

    onewire_sensor_slave #(.CONV_US(CONV)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .temp_in(temp_in), .bus_pull(bus_pull)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_us(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Master reset pulse of len us; checks presence or its absence.
    task automatic bus_reset(input int len, input bit expect_pres, input string tag);
        m_low = 1'b1;
        wait_us(len);
        m_low = 1'b0;
        wait_us(100);
        chk(bus_in == !expect_pres, {tag, " presence level at 100us"}, 32'(bus_in), 32'(!expect_pres));
        wait_us(200);
        chk(bus_pull == 1'b0, {tag, " bus released by 300us"}, 32'(bus_pull), 0);
        wait_us(180);
    endtask

    task automatic write_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            m_low = 1'b1;
            wait_us(b[i] ? 5 : 80);
            m_low = 1'b0;
            wait_us(b[i] ? 80 : 5);
        end
    endtask

    task automatic read_bits(input int n, output logic [31:0] v);
        v = '0;
        for (int i = 0; i < n; i++) begin
            m_low = 1'b1;
            wait_us(3);
            m_low = 1'b0;
            wait_us(9);
            v[i] = bus_in;
            wait_us(48);
            chk(bus_pull == 1'b0, "R7 read-0 hold released by 60us", 32'(bus_pull), 0);
            wait_us(10);
        end
    endtask

    task automatic read_scratch(output logic [31:0] v);
        bus_reset(500, 1'b1, "R2");
        write_byte(8'hCC);
        write_byte(8'hBE);
        read_bits(16, v);
    endtask

    task automatic t_power_on();
        logic [31:0] v;
        chk(bus_pull == 1'b0, "R11 bus_pull after rst_n", 32'(bus_pull), 0);
        read_bits(4, v);
        chk(v[3:0] == 4'hF, "R11 slots before first reset ignored", v, 32'hF);
    endtask

    task automatic t_short_low();
        bus_reset(400, 1'b0, "R1 400us low not a reset");
        bus_reset(470, 1'b0, "R1 470us low not a reset");
        bus_reset(500, 1'b1, "R1 500us low is a reset");
    endtask

    task automatic t_read_init();
        logic [31:0] v;
        read_scratch(v);
        chk(v[15:0] == 16'h0550, "R7 R3 initial scratchpad read LSB first", v, 32'h0550);
        read_bits(6, v);
        chk(v[5:0] == 6'h3F, "R8 slots past 16 bits read 1", v, 32'h3F);
        bus_reset(500, 1'b1, "R10 reset honoured in read mode");
    endtask

    task automatic t_convert();
        logic [31:0] v;
        temp_in = 16'hA5C3;
        bus_reset(500, 1'b1, "R2");
        write_byte(8'hCC);
        write_byte(8'h44);
        wait_us(CONV + 200);
        read_scratch(v);
        chk(v[15:0] == 16'hA5C3, "R5 converted value returned", v, 32'hA5C3);
        temp_in = 16'h7E81;
        read_scratch(v);
        chk(v[15:0] == 16'hA5C3, "R5 scratchpad holds without conversion", v, 32'hA5C3);
    endtask

    task automatic t_reset_mid_conv();
        logic [31:0] v;
        temp_in = 16'h1234;
        bus_reset(500, 1'b1, "R2");
        write_byte(8'hCC);
        write_byte(8'h44);
        read_scratch(v);
        chk(v[15:0] == 16'hA5C3, "R6 old value while converting", v, 32'hA5C3);
        wait_us(4000);
        read_scratch(v);
        chk(v[15:0] == 16'h1234, "R6 conversion survives bus reset", v, 32'h1234);
    endtask

    task automatic t_bad_rom();
        logic [31:0] v;
        bus_reset(500, 1'b1, "R2");
        write_byte(8'h33);
        write_byte(8'hBE);
        read_bits(8, v);
        chk(v[7:0] == 8'hFF, "R4 non-skip first byte ignored", v, 32'hFF);
    endtask

    task automatic t_bad_func();
        logic [31:0] v;
        bus_reset(500, 1'b1, "R2");
        write_byte(8'hCC);
        write_byte(8'h55);
        read_bits(8, v);
        chk(v[7:0] == 8'hFF, "R9 unknown command ignored", v, 32'hFF);
    endtask

    task automatic t_glitch_presence();
        logic [31:0] v;
        m_low = 1'b1;
        wait_us(500);
        m_low = 1'b0;
        wait_us(5);
        m_low = 1'b1;
        wait_us(3);
        m_low = 1'b0;
        wait_us(92);
        chk(bus_in == 1'b0, "R10 presence despite edge in wait", 32'(bus_in), 0);
        wait_us(380);
        write_byte(8'hCC);
        write_byte(8'hBE);
        read_bits(16, v);
        chk(v[15:0] == 16'h1234, "R10 bit count unaffected by ignored edge", v, 32'h1234);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        wait_us(5);
        rst_n = 1'b1;
        wait_us(5);
        t_power_on();
        t_short_low();
        t_read_init();
        t_convert();
        t_reset_mid_conv();
        t_bad_rom();
        t_bad_func();
        t_glitch_presence();
        report();
    end
endmodule